// File: doc/BRIEF.md
# Erasable Byte-Wide Program Memory Model

This block is a cycle-based, synthesizable stand-in for a byte-wide memory that is erased to all ones and programmed one byte at a time by clearing bits. Two active-low controls, a chip select that doubles as the program strobe and an output gate, are combined with a programming-voltage flag to pick one of six operating states. In the three normal-voltage states the part is idle (standby), selected but not driving (output disable), or reading. In the three high-voltage states it is writing (program), reading back (verify), or deselected (inhibit).

The data output is qualified by `outEn`, which stands in for a tri-state driver. It is registered, so any change of the inputs shows up at the outputs one clock later. A separate identification path is selected by a flag that stands for a raised voltage on one address pin. It returns a fixed manufacturer byte or device byte in place of array contents.

Erase is modelled as a sweep that writes all ones into one location per cycle. Reset starts the same sweep, so the array comes out of reset in a known, blank state without a reset net on every storage bit.

Top module: `promCore`

## Requirements
- R1: With `ceN` high (standby at normal voltage, program inhibit at high voltage), `outEn` is 0 and `dataOut` is 0 on the next cycle, whatever `oeN` is.
- R2: At normal voltage, with `ceN` low and `oeN` high (output disable), `outEn` is 0 and `dataOut` is 0 on the next cycle.
- R3: At normal voltage, with `ceN` and `oeN` both low and the identification path not selected, `outEn` is 1 on the next cycle and `dataOut` is the byte stored at `addr`.
- R4: At normal voltage, with `ceN` and `oeN` low, `idHi` set and every address bit above bit 0 low, the next cycle shows `outEn`=1 and `dataOut`=0x8F when `addr[0]` is 0, or 0x04 when `addr[0]` is 1. With `idHi` set but any upper address bit high, the read is an ordinary array read.
- R5: With `progHi` set and `oeN` high, a cycle in which `ceN` is low after being high in the cycle before writes `stored AND dataIn` into the location at `addr`. `outEn` stays 0 throughout programming.
- R6: Holding `ceN` low for further cycles in program mode writes nothing more. Only a fresh high-to-low transition writes again.
- R7: With `progHi` set and `ceN`, `oeN` both low (verify), the next cycle shows `outEn`=1 and `dataOut` = the stored byte. The identification path is not used in this state.
- R8: Programming never turns a 0 bit into a 1: 1 bits in `dataIn` leave their cells unchanged. After an erase every bit reads 1.
- R9: `eraseReq` sampled high while `eraseBusy` is 0 raises `eraseBusy` on the next cycle. `eraseBusy` then stays high for exactly 2^ADDR_W cycles while every location is loaded with 0xFF, and then falls.
- R10: While `eraseBusy` is high, `outEn` is 0 on the next cycle, program pulses change no location, and further `eraseReq` pulses are ignored.
- R11: During and directly after reset, `outEn` is 0, `dataOut` is 0 and `eraseBusy` is 1. The reset sweep takes 2^ADDR_W cycles, just as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; starts an erase sweep |
| ceN | input | 1 | Active-low chip select and program strobe |
| oeN | input | 1 | Active-low output gate |
| progHi | input | 1 | Programming voltage present |
| idHi | input | 1 | Identification voltage present on the ID address pin |
| eraseReq | input | 1 | Request to erase the whole array |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Byte to program |
| dataOut | output | DATA_W | Byte read; 0 when not driven |
| outEn | output | 1 | Output drive qualifier (low means high impedance) |
| eraseBusy | output | 1 | Erase sweep in progress |

## Verification
The assertions assume that the inputs are stable between the clock edges and that nothing outside drives the data pins while `outEn` is high. The bench changes inputs only on the falling clock edge and never checks data on a disabled output.

The identification property assumes that `addr` is exactly 0 or 1 when `idHi` is used for a code read. The random stimulus therefore draws addresses from the lowest four locations half of the time, so that both codes and the fall-back to an ordinary read occur often. Erase requests are kept rare in the random phase, so that most cycles reach the array rather than the sweep.

// File: rtl/promPkg.sv
package promPkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_DISABLE,
    MD_READ,
    MD_PROG,
    MD_VERIFY,
    MD_INHIBIT,
    MD_SWEEP
  } promMode_t;

  // Strobes from the control decoder to the storage datapath
  typedef struct packed {
    logic wrEn;   // AND-program the addressed byte
    logic clrEn;  // load ones at the sweep address
    logic rdEn;   // drive the output next cycle
    logic idSel;  // drive an identification byte instead of the array
  } promStrb_t;

endpackage

// File: rtl/promCtrl.sv
module promCtrl
  import promPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progHi,
  input  logic              idHi,
  input  logic              eraseReq,
  input  logic [ADDR_W-2:0] addrUpper,
  output promStrb_t         strb,
  output logic [ADDR_W-1:0] sweepAddr,
  output logic              eraseBusy
);

  promMode_t mode;
  logic      ceNPrev;
  logic      busyQ;

  always_comb begin
    if (busyQ)        mode = MD_SWEEP;
    else if (!progHi) mode = ceN ? MD_STANDBY : (oeN ? MD_DISABLE : MD_READ);
    else              mode = ceN ? MD_INHIBIT : (oeN ? MD_PROG : MD_VERIFY);
  end

  always_comb begin
    strb       = '0;
    strb.clrEn = busyQ;
    strb.wrEn  = (mode == MD_PROG) && ceNPrev;
    strb.rdEn  = (mode == MD_READ) || (mode == MD_VERIFY);
    strb.idSel = (mode == MD_READ) && idHi && (addrUpper == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b1;
      sweepAddr <= '0;
      ceNPrev   <= 1'b1;
    end else begin
      ceNPrev <= ceN;
      if (busyQ) begin
        sweepAddr <= sweepAddr + 1'b1;
        if (&sweepAddr) busyQ <= 1'b0;
      end else if (eraseReq) begin
        busyQ     <= 1'b1;
        sweepAddr <= '0;
      end
    end
  end

  assign eraseBusy = busyQ;

endmodule

// File: rtl/promArray.sv
module promArray
  import promPkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 'h8F,
  parameter logic [DATA_W-1:0] DEV_ID = 'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  promStrb_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] sweepAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] idByte;
  logic [DATA_W-1:0] rdByte;

  always_ff @(posedge clk) begin
    if (strb.clrEn)     cells[sweepAddr] <= '1;
    else if (strb.wrEn) cells[addr]      <= cells[addr] & dataIn;
  end

  always_comb begin
    idByte = addr[0] ? DEV_ID : MFR_ID;
    rdByte = strb.idSel ? idByte : cells[addr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEn   <= 1'b0;
      dataOut <= '0;
    end else begin
      outEn   <= strb.rdEn;
      dataOut <= strb.rdEn ? rdByte : '0;
    end
  end

endmodule

// File: rtl/promCore.sv
module promCore
  import promPkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 'h8F,
  parameter logic [DATA_W-1:0] DEV_ID = 'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              progHi,
  input  logic              idHi,
  input  logic              eraseReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn,
  output logic              eraseBusy
);

  promStrb_t         strb;
  logic [ADDR_W-1:0] sweepAddr;

  promCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ceN       (ceN),
    .oeN       (oeN),
    .progHi    (progHi),
    .idHi      (idHi),
    .eraseReq  (eraseReq),
    .addrUpper (addr[ADDR_W-1:1]),
    .strb      (strb),
    .sweepAddr (sweepAddr),
    .eraseBusy (eraseBusy)
  );

  promArray #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
  ) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addr      (addr),
    .sweepAddr (sweepAddr),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .outEn     (outEn)
  );

endmodule

// File: rtl/promCore_chk.sv
module promCore_chk #(
  parameter int                ADDR_W = 8,
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 'h8F,
  parameter logic [DATA_W-1:0] DEV_ID = 'h04
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              oeN,
  input logic              progHi,
  input logic              idHi,
  input logic              eraseReq,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataOut,
  input logic              outEn,
  input logic              eraseBusy
);

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!outEn && dataOut == '0));

  a_r2_gate_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!progHi && !ceN && oeN) |=> !outEn);

  a_r3_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseBusy && !ceN && !oeN) |=> outEn);

  a_r4_mfr_code: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseBusy && !progHi && !ceN && !oeN && idHi && addr == '0)
      |=> (outEn && dataOut == MFR_ID));

  a_r4_dev_code: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseBusy && !progHi && !ceN && !oeN && idHi && addr == ADDR_W'(1))
      |=> (outEn && dataOut == DEV_ID));

  a_r5_prog_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (progHi && oeN) |=> !outEn);

  a_r9_erase_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseBusy && eraseReq) |=> eraseBusy);

  a_r10_sweep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |=> !outEn);

endmodule

bind promCore promCore_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MFR_ID (MFR_ID),
  .DEV_ID (DEV_ID)
) u_chk (.*);

// File: tb/promCore_bench.sv
`timescale 1ns/1ps
module promCore_bench;

  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1, oeN = 1'b1, progHi = 1'b0, idHi = 1'b0, eraseReq = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dataIn = '0;
  logic [7:0]    dataOut;
  logic          outEn, eraseBusy;

  int vecCount = 0;
  int errCount = 0;

  logic [7:0] model [DEPTH];
  int         busyLeft = DEPTH;
  logic       prevCe = 1'b1;

  always #2.5 clk = ~clk;

  promCore #(.ADDR_W(AW)) u_promCore (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .progHi(progHi), .idHi(idHi),
    .eraseReq(eraseReq), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .outEn(outEn), .eraseBusy(eraseBusy)
  );

  function automatic logic [8:0] expRead(input logic c, o, p, i,
                                         input logic [AW-1:0] a);
    if (c || o)                       return 9'h000;
    if (!p && i && a[AW-1:1] == '0)   return {1'b1, (a[0] ? 8'h04 : 8'h8F)};
    return {1'b1, model[a]};
  endfunction

  // Apply one cycle at a falling edge, model it, check at the next falling edge.
  task automatic cyc(input logic c, o, p, i, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic e, input string tag);
    logic [8:0] ex;
    logic       exBusy;
    ceN = c; oeN = o; progHi = p; idHi = i; addr = a; dataIn = d; eraseReq = e;
    exBusy = (busyLeft > 0);
    if (exBusy) ex = 9'h000;
    else begin
      ex = expRead(c, o, p, i, a);
      if (p && o && !c && prevCe) model[a] = model[a] & d;
    end
    if (busyLeft > 0) busyLeft--;
    else if (e) begin
      busyLeft = DEPTH;
      for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    end
    prevCe = c;
    vecCount++;
    if (eraseBusy !== exBusy) begin
      errCount++;
      $display("FAIL %s (R9): eraseBusy=%0b expected %0b", tag, eraseBusy, exBusy);
    end
    @(posedge clk);
    @(negedge clk);
    if (outEn !== ex[8] || dataOut !== ex[7:0]) begin
      errCount++;
      $display("FAIL %s: outEn=%0b dataOut=%02h expected outEn=%0b dataOut=%02h",
               tag, outEn, dataOut, ex[8], ex[7:0]);
    end
  endtask

  task automatic progPulse(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    cyc(1, 1, 1, 0, a, d, 0, tag);
    cyc(0, 1, 1, 0, a, d, 0, tag);
    cyc(1, 1, 1, 0, a, d, 0, tag);
  endtask

  task automatic idleUntilIdle(input string tag);
    while (busyLeft > 0) cyc(0, 0, 0, 0, AW'(busyLeft), 8'h00, 0, tag);
  endtask

  initial begin
    #1_000_000;
    errCount++;
    $display("FAIL R9 watchdog: run still active, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    vecCount++;
    if (outEn !== 1'b0 || dataOut !== 8'h00 || eraseBusy !== 1'b1) begin
      errCount++;
      $display("FAIL R11 reset: outEn=%0b dataOut=%02h busy=%0b expected 0 00 1",
               outEn, dataOut, eraseBusy);
    end
    rstN = 1'b1;

    // R11 / R10: reset sweep, outputs stay off while reading is attempted
    idleUntilIdle("R11 R10 reset sweep");

    // R8: blank array reads all ones; R3 ordinary read
    cyc(0, 0, 0, 0, 8'd5, 8'h00, 0, "R8 R3 blank read");
    cyc(0, 0, 0, 0, 8'd200, 8'h00, 0, "R8 R3 blank read hi");

    // R5 program, R7 verify
    progPulse(8'd5, 8'hA5, "R5 program");
    cyc(0, 0, 1, 0, 8'd5, 8'h00, 0, "R7 verify");
    cyc(0, 0, 0, 0, 8'd5, 8'h00, 0, "R3 read programmed");

    // R8: only clearing; 1 bits leave cells unchanged
    progPulse(8'd9, 8'h0F, "R8 first clear");
    progPulse(8'd9, 8'hF0, "R8 second clear");
    progPulse(8'd9, 8'hFF, "R8 ones no effect");
    cyc(0, 0, 1, 0, 8'd9, 8'h00, 0, "R8 verify zero");

    // R6: strobe held low writes only once
    cyc(1, 1, 1, 0, 8'd12, 8'hFE, 0, "R6 setup");
    cyc(0, 1, 1, 0, 8'd12, 8'hFE, 0, "R6 edge");
    cyc(0, 1, 1, 0, 8'd12, 8'h00, 0, "R6 held");
    cyc(0, 1, 1, 0, 8'd12, 8'h00, 0, "R6 held");
    cyc(0, 0, 1, 0, 8'd12, 8'h00, 0, "R6 verify");

    // R4 identification and fall-back
    cyc(0, 0, 0, 1, 8'd0, 8'h00, 0, "R4 manufacturer");
    cyc(0, 0, 0, 1, 8'd1, 8'h00, 0, "R4 device");
    cyc(0, 0, 0, 1, 8'd5, 8'h00, 0, "R4 upper bit fallback");
    cyc(0, 0, 1, 1, 8'd0, 8'h00, 0, "R7 no id in verify");

    // R1 / R2 deselect and gate
    cyc(1, 0, 0, 0, 8'd5, 8'h00, 0, "R1 standby");
    cyc(1, 0, 1, 0, 8'd5, 8'h00, 0, "R1 inhibit");
    cyc(0, 1, 0, 0, 8'd5, 8'h00, 0, "R2 disable");

    // R9 erase, R10 program during sweep ignored
    cyc(1, 1, 0, 0, 8'd0, 8'h00, 1, "R9 erase request");
    repeat (20) cyc(0, 0, 0, 0, 8'd0, 8'h00, 1, "R10 busy read/erase");
    progPulse(8'd0, 8'h00, "R10 program while busy");
    idleUntilIdle("R9 sweep");
    cyc(0, 0, 0, 0, 8'd0, 8'h00, 0, "R10 write ignored");
    cyc(0, 0, 0, 0, 8'd9, 8'h00, 0, "R9 erased");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      a = ($urandom % 2) ? AW'($urandom % 4) : AW'($urandom);
      cyc(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, a,
          8'($urandom), ($urandom % 300) == 0, "R1 R2 R3 R4 R5 R7 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule